// File: doc/BRIEF.md
# Irregular-Sequence JK State Counter

A 3-bit synchronous counter that repeats the fixed cycle 1, 2, 3, 5, 7 and then returns to 1. It does not count in binary. Each state bit sits in its own JK storage cell. A combinational excitation stage computes the J and K inputs of every cell from the present state. The three codes that are not in the cycle (0, 4 and 6) are sent to 7, so a corrupted state rejoins the cycle after a single edge.

The cells update on the rising clock edge. An active-low asynchronous reset puts the counter in state 1. A count enable gates the stepping. When it is low, every J and K is driven to 0 and all bits hold their value.

A seed port loads any 3-bit code, including the unused ones, through the same JK cells. It does this by driving J with the seed and K with its complement. This is how the illegal codes are placed in the register to test the recovery path. The applied J and K vectors are brought out so the excitation can be checked bit by bit.

Top module: `jk_seq_counter`

## Requirements
- R1: While rst_ni is low, state_o is 3'b001 at once, without waiting for a clock edge. Reset takes priority over seed_en_i and en_i.
- R2: With en_i high and seed_en_i low, each rising edge moves state_o through 1→2→3→5→7, and from 7 back to 1.
- R3: With en_i high and seed_en_i low, the codes 0, 4 and 6 move to 7 on the next rising edge.
- R4: Each bit i obeys next = j_o[i]·~q + ~k_o[i]·q, where q is state_o[i]. J=K=0 holds, J=0 K=1 clears, J=1 K=0 sets, and J=K=1 toggles.
- R5: With en_i and seed_en_i both low, j_o and k_o are 3'b000 and state_o keeps its value across edges.
- R6: With seed_en_i high, state_o equals seed_i after the next rising edge. The seed takes priority over en_i.
- R7: While counting, for present state q (bit 2 = MSB) the excitation is J2 = ~(q1^q0), K2 = q1&q0, J1 = 1, K1 = q0, J0 = 1 and K0 = ~q2&~q1. Every don't-care term is fixed by these equations.
- R8: With seed_en_i high, j_o equals seed_i and k_o equals ~seed_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low, loads state 1 |
| en_i | input | 1 | Count enable |
| seed_en_i | input | 1 | Load seed_i on the next edge |
| seed_i | input | 3 | Code to load |
| state_o | output | 3 | Present counter state |
| j_o | output | 3 | Applied J input of each cell |
| k_o | output | 3 | Applied K input of each cell |

## Verification
Seed loading and counting can both be requested in the same cycle. So can reset and seed loading. The bench raises en_i together with seed_en_i while the counter sits on a cycle state. It expects the seeded code, not the successor, and expects j_o and k_o to follow the seed. It also drops rst_ni during an active seed request between clock edges, and expects state 1 before the next edge and still after it.

// File: rtl/jk_seq_pkg.sv
package jk_seq_pkg;
  localparam int CNT_W = 3;
  localparam logic [CNT_W-1:0] RST_CODE = 3'd1;

  typedef enum logic [1:0] {
    JK_HOLD = 2'b00,
    JK_CLR  = 2'b01,
    JK_SET  = 2'b10,
    JK_TGL  = 2'b11
  } jk_op_e;
endpackage

// File: rtl/jk_cell.sv
module jk_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic j_i,
  input  logic k_i,
  output logic q_o
);
  import jk_seq_pkg::*;

  jk_op_e op;
  assign op = jk_op_e'({j_i, k_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RST_VAL;
    else begin
      case (op)
        JK_HOLD: q_o <= q_o;
        JK_CLR:  q_o <= 1'b0;
        JK_SET:  q_o <= 1'b1;
        JK_TGL:  q_o <= ~q_o;
        default: q_o <= q_o;
      endcase
    end
  end

  // R4: characteristic equation
  a_r4_jk_law: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> q_o == (($past(j_i) & ~$past(q_o)) | (~$past(k_i) & $past(q_o))));
endmodule

// File: rtl/jk_seq_exc.sv
module jk_seq_exc
  import jk_seq_pkg::*;
(
  input  logic [CNT_W-1:0] q_i,
  input  logic             en_i,
  input  logic             seed_en_i,
  input  logic [CNT_W-1:0] seed_i,
  output logic [CNT_W-1:0] j_o,
  output logic [CNT_W-1:0] k_o
);
  logic [CNT_W-1:0] cnt_j, cnt_k;

  // don't-cares resolved to minimal terms; 0,4,6 land on 7
  always_comb begin
    cnt_j[2] = ~(q_i[1] ^ q_i[0]);
    cnt_k[2] = q_i[1] & q_i[0];
    cnt_j[1] = 1'b1;
    cnt_k[1] = q_i[0];
    cnt_j[0] = 1'b1;
    cnt_k[0] = ~q_i[2] & ~q_i[1];
  end

  always_comb begin
    if (seed_en_i) begin
      j_o = seed_i;
      k_o = ~seed_i;
    end else if (en_i) begin
      j_o = cnt_j;
      k_o = cnt_k;
    end else begin
      j_o = '0;
      k_o = '0;
    end
  end
endmodule

// File: rtl/jk_seq_counter.sv
module jk_seq_counter
  import jk_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             seed_en_i,
  input  logic [CNT_W-1:0] seed_i,
  output logic [CNT_W-1:0] state_o,
  output logic [CNT_W-1:0] j_o,
  output logic [CNT_W-1:0] k_o
);
  logic [CNT_W-1:0] q, j, k;

  jk_seq_exc u_exc (
    .q_i      (q),
    .en_i     (en_i),
    .seed_en_i(seed_en_i),
    .seed_i   (seed_i),
    .j_o      (j),
    .k_o      (k)
  );

  for (genvar i = 0; i < CNT_W; i++) begin : g_bit
    jk_cell #(.RST_VAL(RST_CODE[i])) u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .j_i   (j[i]),
      .k_i   (k[i]),
      .q_o   (q[i])
    );
  end

  assign state_o = q;
  assign j_o     = j;
  assign k_o     = k;

  logic step;
  assign step = en_i & ~seed_en_i;

  // R2: cycle order
  a_r2_1to2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && q == 3'd1) |=> q == 3'd2);
  a_r2_2to3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && q == 3'd2) |=> q == 3'd3);
  a_r2_3to5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && q == 3'd3) |=> q == 3'd5);
  a_r2_5to7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && q == 3'd5) |=> q == 3'd7);
  a_r2_7to1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && q == 3'd7) |=> q == 3'd1);
  // R3: unused codes recover
  a_r3_recover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && (q == 3'd0 || q == 3'd4 || q == 3'd6)) |=> q == 3'd7);
  // R5: idle holds
  a_r5_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !seed_en_i) |=> $stable(q));
  // R6: seed load wins
  a_r6_seed_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_en_i |=> q == $past(seed_i));
endmodule

// File: tb/sim_jk_seq_counter.sv
module sim_jk_seq_counter;
  localparam int CLK_PERIOD = 10;
  // {code, next, j, k}
  localparam logic [11:0] VEC [8] = '{
    {3'd0, 3'd7, 3'b111, 3'b001},
    {3'd1, 3'd2, 3'b011, 3'b011},
    {3'd2, 3'd3, 3'b011, 3'b000},
    {3'd3, 3'd5, 3'b111, 3'b110},
    {3'd4, 3'd7, 3'b111, 3'b000},
    {3'd5, 3'd7, 3'b011, 3'b010},
    {3'd6, 3'd7, 3'b011, 3'b000},
    {3'd7, 3'd1, 3'b111, 3'b110}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       seed_en = 1'b0;
  logic [2:0] seed = 3'd0;
  logic [2:0] state, j, k;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  jk_seq_counter u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .seed_en_i(seed_en),
    .seed_i(seed), .state_o(state), .j_o(j), .k_o(k)
  );

  task automatic chk(input bit ok, input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    chk(1'b0, "watchdog", 6'd0, 6'd1);
    finish_run();
  end

  initial begin
    logic [2:0] q_prev, j_prev, k_prev, exp_s;
    #(CLK_PERIOD * 2 + 1);
    chk(state == 3'd1, "R1 reset state", {3'd0, state}, 6'd1);
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    chk(state == 3'd1, "R5 idle after reset", {3'd0, state}, 6'd1);
    chk(j == 3'd0 && k == 3'd0, "R5 idle jk zero", {j, k}, 6'd0);

    // table walk over all eight codes
    foreach (VEC[i]) begin
      seed = VEC[i][11:9]; seed_en = 1'b1; en = 1'b0;
      #1;
      chk(j == seed && k == ~seed, "R8 seed jk", {j, k}, {seed, ~seed});
      tick();
      chk(state == VEC[i][11:9], "R6 seed load", {3'd0, state}, {3'd0, VEC[i][11:9]});
      seed_en = 1'b0; en = 1'b1;
      #1;
      chk(j == VEC[i][5:3] && k == VEC[i][2:0], "R7 excitation", {j, k}, VEC[i][5:0]);
      q_prev = state; j_prev = j; k_prev = k;
      tick();
      if (VEC[i][11:9] inside {3'd0, 3'd4, 3'd6})
        chk(state == VEC[i][8:6], "R3 recover to 7", {3'd0, state}, {3'd0, VEC[i][8:6]});
      else
        chk(state == VEC[i][8:6], "R2 cycle step", {3'd0, state}, {3'd0, VEC[i][8:6]});
      exp_s = (j_prev & ~q_prev) | (~k_prev & q_prev);
      chk(state == exp_s, "R4 jk law", {3'd0, state}, {3'd0, exp_s});
      en = 1'b0;
    end

    // full cycle twice from reset
    rst_n = 1'b0; #1;
    chk(state == 3'd1, "R1 async reset", {3'd0, state}, 6'd1);
    @(negedge clk); rst_n = 1'b1; en = 1'b1;
    for (int n = 0; n < 10; n++) begin
      logic [2:0] seq [5];
      seq = '{3'd2, 3'd3, 3'd5, 3'd7, 3'd1};
      tick();
      chk(state == seq[n % 5], "R2 full cycle", {3'd0, state}, {3'd0, seq[n % 5]});
    end

    // idle hold mid-cycle
    tick();                      // 1 -> 2
    en = 1'b0;
    for (int n = 0; n < 3; n++) begin
      tick();
      chk(state == 3'd2, "R5 hold", {3'd0, state}, 6'd2);
    end
    chk(j == 3'd0 && k == 3'd0, "R5 jk zero", {j, k}, 6'd0);

    // seed and enable together: seed wins
    en = 1'b1; seed_en = 1'b1; seed = 3'd6;
    #1;
    chk(j == 3'd6 && k == 3'd1, "R8 seed over enable jk", {j, k}, {3'd6, 3'd1});
    tick();
    chk(state == 3'd6, "R6 seed over enable", {3'd0, state}, 6'd6);
    seed_en = 1'b0;
    tick();
    chk(state == 3'd7, "R3 recover from 6", {3'd0, state}, 6'd7);

    // reset against seed
    seed_en = 1'b1; seed = 3'd4;
    #2 rst_n = 1'b0;
    #1;
    chk(state == 3'd1, "R1 reset over seed", {3'd0, state}, 6'd1);
    tick();
    chk(state == 3'd1, "R1 reset held over seed", {3'd0, state}, 6'd1);
    rst_n = 1'b1; seed_en = 1'b0; en = 1'b0;
    tick();
    chk(state == 3'd1, "R5 hold after reset", {3'd0, state}, 6'd1);

    finish_run();
  end
endmodule